// File: doc/BRIEF.md
# Regulator Standby Wake-Up Sequencer

This block decides whether the supply regulator drops into its low-power standby state while the device sleeps, and when the core may run again after a wake. At the moment sleep is requested, a hold-on control bit is sampled. With that bit at 0, the regulator is commanded into standby for the whole sleep period. A later wake event then starts a settle countdown, and the core stays halted until the countdown ends. With the bit at 1, the regulator stays on while the device sleeps, and a wake event releases the core on the next cycle.

The settle length is chosen by a two-bit wake-time code, in cycles of the slow reference clock that also clocks the block. An under-voltage indication from the regulator produces a one-cycle brown-out reset pulse. It also sets a sticky flag that only software or power-on reset can clear. A brown-out puts the sequencer back in the running state.

Top module: `vreg_wake_seq`

## Requirements
- R1: After power-on reset, `core_run` = 1, `reg_stby` = 0, `wake_done` = 0, `bor_rst` = 0 and `bor_flag` = 0.
- R2: While running, `sleep_req` = 1 with `hold_on` = 0 makes `core_run` = 0 and `reg_stby` = 1 from the next cycle on.
- R3: `sleep_req` = 1 with `hold_on` = 1 makes `core_run` = 0 and keeps `reg_stby` = 0. A wake event then gives `core_run` = 1 and `wake_done` = 1 on the very next cycle. Changing `hold_on` during sleep has no effect.
- R4: A wake event during regulator standby drops `reg_stby` on the next cycle and keeps `core_run` = 0 for exactly N cycles. On the cycle after that, `core_run` = 1 and `wake_done` = 1.
- R5: N is taken from `wake_sel` at the edge where the wake event is accepted. Code 2'b01 gives DLY_SHORT. Code 2'b11 gives DLY_LONG. The reserved codes 2'b00 and 2'b10 also give DLY_LONG.
- R6: A wake event while the settle countdown runs, or while the core is running, changes no output and no timing.
- R7: `sleep_req` is accepted only while the core is running in steady state. During the release cycle and during settling it is ignored.
- R8: `uv_det` = 1 at an edge gives `bor_rst` = 1 and `bor_flag` = 1 on the next cycle. From any state, it also returns the block to `core_run` = 1 with `reg_stby` = 0.
- R9: `bor_flag` clears only when `flag_wr_en` = 1 with `flag_wr_val` = 0. Writing 1 has no effect. A simultaneous under-voltage wins over a clear.
- R10: `wake_done` is high for exactly one cycle per wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Power-on reset, active low |
| sleep_req | input | 1 | Sleep entry request |
| wake_evt | input | 1 | Wake event |
| hold_on | input | 1 | 1 keeps the regulator on during sleep |
| wake_sel | input | 2 | Settle time code |
| uv_det | input | 1 | Regulator under-voltage indication |
| flag_wr_en | input | 1 | Software write strobe for the brown-out flag |
| flag_wr_val | input | 1 | Value written to the brown-out flag |
| reg_stby | output | 1 | Regulator standby command |
| core_run | output | 1 | Core released (not held in sleep or wake-up) |
| wake_done | output | 1 | One-cycle pulse when the core is released |
| bor_rst | output | 1 | Brown-out reset pulse |
| bor_flag | output | 1 | Sticky brown-out flag |

## Verification
The hardest situations to reach are the single release cycle and the last settle cycle, where a stray sleep request or wake event must be ignored. An under-voltage must also be seen cutting a countdown short. The stimulus reaches these points by timing its inputs off the wake it has just driven. For example, it raises `sleep_req` on the negative edge right after a bypassed wake, so it lands in the release cycle. It also fires `uv_det` a few cycles into a long settle. A behavioural model checks every output on every cycle. Separate counted measurements confirm the settle length for each of the four wake-time codes.

// File: rtl/vws_pkg.sv
package vws_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE   = 2'd0,
        ST_STANDBY  = 2'd1,
        ST_SETTLING = 2'd2,
        ST_RELEASE  = 2'd3
    } vws_state_e;

    localparam logic [1:0] SEL_SHORT = 2'b01;
    localparam logic [1:0] SEL_LONG  = 2'b11;

endpackage

// File: rtl/vws_delay_sel.sv
module vws_delay_sel #(
    parameter int DLY_SHORT = 8,
    parameter int DLY_LONG  = 24,
    parameter int CW        = 5
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] cycles
);
    import vws_pkg::*;

    localparam logic [CW-1:0] SHORT_V = CW'(DLY_SHORT);
    localparam logic [CW-1:0] LONG_V  = CW'(DLY_LONG);

    // reserved codes fall back to the longest settle time
    always_comb begin
        case (sel)
            SEL_SHORT: cycles = SHORT_V;
            SEL_LONG:  cycles = LONG_V;
            default:   cycles = LONG_V;
        endcase
    end

endmodule

// File: rtl/vws_settle_cnt.sv
module vws_settle_cnt #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.cnt = load_val - 1'b1;
        end else if (run && cnt_q.cnt != '0) begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = run && (cnt_q.cnt == '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q.cnt != '0) |=> (cnt_q.cnt == $past(cnt_q.cnt) - 1'b1)); // R4

endmodule

// File: rtl/vws_bor_flag.sv
module vws_bor_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_det,
    input  logic wr_en,
    input  logic wr_val,
    output logic flag,
    output logic bor_rst
);
    typedef struct packed {
        logic flag;
        logic rst;
    } bor_reg_t;

    bor_reg_t bor_d, bor_q;

    always_comb begin
        bor_d     = bor_q;
        bor_d.rst = uv_det;
        if (uv_det) begin
            bor_d.flag = 1'b1;
        end else if (wr_en && !wr_val) begin
            bor_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bor_q <= '0;
        end else begin
            bor_q <= bor_d;
        end
    end

    assign flag    = bor_q.flag;
    assign bor_rst = bor_q.rst;

    AST_UV_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        uv_det |=> (flag && bor_rst)); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && !wr_val)) |=> flag); // R9

endmodule

// File: rtl/vreg_wake_seq.sv
module vreg_wake_seq #(
    parameter int DLY_SHORT = 8,
    parameter int DLY_LONG  = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_evt,
    input  logic       hold_on,
    input  logic [1:0] wake_sel,
    input  logic       uv_det,
    input  logic       flag_wr_en,
    input  logic       flag_wr_val,
    output logic       reg_stby,
    output logic       core_run,
    output logic       wake_done,
    output logic       bor_rst,
    output logic       bor_flag
);
    import vws_pkg::*;

    localparam int DLY_MAX = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
    localparam int CW      = $clog2(DLY_MAX + 1);

    typedef struct packed {
        vws_state_e state;
        logic       mode;   // 1: regulator taken into standby for this sleep
    } fsm_reg_t;

    fsm_reg_t fsm_d, fsm_q;

    logic          cnt_load;
    logic          cnt_done;
    logic [CW-1:0] settle_cycles;

    vws_delay_sel #(
        .DLY_SHORT (DLY_SHORT),
        .DLY_LONG  (DLY_LONG),
        .CW        (CW)
    ) i_delay_sel (
        .sel    (wake_sel),
        .cycles (settle_cycles)
    );

    vws_settle_cnt #(
        .CW (CW)
    ) i_settle_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (settle_cycles),
        .run      (fsm_q.state == ST_SETTLING),
        .done     (cnt_done)
    );

    vws_bor_flag i_bor_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .uv_det  (uv_det),
        .wr_en   (flag_wr_en),
        .wr_val  (flag_wr_val),
        .flag    (bor_flag),
        .bor_rst (bor_rst)
    );

    always_comb begin
        fsm_d    = fsm_q;
        cnt_load = 1'b0;
        if (uv_det) begin
            fsm_d.state = ST_ACTIVE;
        end else begin
            case (fsm_q.state)
                ST_ACTIVE: begin
                    if (sleep_req) begin
                        fsm_d.state = ST_STANDBY;
                        fsm_d.mode  = !hold_on;
                    end
                end
                ST_STANDBY: begin
                    if (wake_evt) begin
                        if (fsm_q.mode) begin
                            fsm_d.state = ST_SETTLING;
                            cnt_load    = 1'b1;
                        end else begin
                            fsm_d.state = ST_RELEASE;
                        end
                    end
                end
                ST_SETTLING: begin
                    if (cnt_done) begin
                        fsm_d.state = ST_RELEASE;
                    end
                end
                default: begin
                    fsm_d.state = ST_ACTIVE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_ACTIVE, mode: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign reg_stby  = (fsm_q.state == ST_STANDBY) && fsm_q.mode;
    assign core_run  = (fsm_q.state == ST_ACTIVE) || (fsm_q.state == ST_RELEASE);
    assign wake_done = (fsm_q.state == ST_RELEASE);

    AST_STBY_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_stby |-> !core_run); // R2

    AST_BYPASS_NO_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_STANDBY && !fsm_q.mode && wake_evt && !uv_det) |=> wake_done); // R3

    AST_STBY_OFF_ON_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_stby && wake_evt && !uv_det) |=> (!reg_stby && !core_run)); // R4

    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_SETTLING && !cnt_done && !uv_det) |=> (fsm_q.state == ST_SETTLING)); // R6

    AST_NO_SLEEP_IN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_done && !uv_det) |=> (core_run && !wake_done)); // R7

    AST_UV_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_det |=> (core_run && !reg_stby)); // R8

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done); // R10

endmodule

// File: tb/test_vreg_wake_seq.sv
module test_vreg_wake_seq;

    localparam int SHORT = 8;
    localparam int LONG  = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       hold_on = 1'b0;
    logic [1:0] wake_sel = 2'b01;
    logic       uv_det = 1'b0;
    logic       flag_wr_en = 1'b0;
    logic       flag_wr_val = 1'b0;
    logic       reg_stby, core_run, wake_done, bor_rst, bor_flag;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    vreg_wake_seq #(.DLY_SHORT(SHORT), .DLY_LONG(LONG)) i_vreg_wake_seq (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
        .hold_on(hold_on), .wake_sel(wake_sel), .uv_det(uv_det),
        .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val),
        .reg_stby(reg_stby), .core_run(core_run), .wake_done(wake_done),
        .bor_rst(bor_rst), .bor_flag(bor_flag)
    );

    // behavioural reference model
    int m_asleep, m_stby, m_left, m_rel, m_flag, m_bor;

    function automatic int settle_len(logic [1:0] s);
        return (s == 2'b01) ? SHORT : LONG;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_asleep = 0; m_stby = 0; m_left = 0; m_rel = 0; m_flag = 0; m_bor = 0;
        end else begin
            m_bor = uv_det;
            if (uv_det) m_flag = 1;
            else if (flag_wr_en && !flag_wr_val) m_flag = 0;
            if (uv_det) begin
                m_asleep = 0; m_left = 0; m_rel = 0;
            end else if (m_rel != 0) begin
                m_rel = 0;
            end else if (m_left > 0) begin
                m_left--;
                if (m_left == 0) m_rel = 1;
            end else if (m_asleep != 0) begin
                if (wake_evt) begin
                    m_asleep = 0;
                    if (m_stby != 0) m_left = settle_len(wake_sel);
                    else m_rel = 1;
                end
            end else if (sleep_req) begin
                m_asleep = 1;
                m_stby = hold_on ? 0 : 1;
            end
        end
    end

    task automatic cmp(string name, logic act, int exp);
        checks++;
        if (act !== exp[0]) begin
            errors++;
            $display("FAIL %s: %s actual=%0b expected=%0d", cur_req, name, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cmp("core_run", core_run, (m_asleep == 0 && m_left == 0) ? 1 : 0);
            cmp("reg_stby", reg_stby, (m_asleep != 0 && m_stby != 0) ? 1 : 0);
            cmp("wake_done", wake_done, m_rel);
            cmp("bor_rst", bor_rst, m_bor);
            cmp("bor_flag", bor_flag, m_flag);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sleep_now(logic keep);
        hold_on = keep; sleep_req = 1'b1;
        cyc(1);
        sleep_req = 1'b0;
    endtask

    task automatic wake_now();
        wake_evt = 1'b1;
        cyc(1);
        wake_evt = 1'b0;
    endtask

    // R5: counted settle length for one wake-time code
    task automatic measure(logic [1:0] code, int n, string tag);
        int k;
        cur_req = tag;
        sleep_now(1'b0);
        cyc(2);
        wake_sel = code;
        wake_evt = 1'b1;
        cyc(1);
        wake_evt = 1'b0;
        k = 1;
        while (!wake_done && k < 200) begin
            cyc(1);
            k++;
        end
        checks++;
        if (k != n + 1) begin
            errors++;
            $display("FAIL %s: code %b settle actual=%0d expected=%0d", tag, code, k - 1, n);
        end
        cyc(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        cur_req = "R1";
        cmp("core_run", core_run, 1);
        cmp("reg_stby", reg_stby, 0);
        cmp("bor_flag", bor_flag, 0);
        cyc(2);

        // R2 R4 standby entry and timed wake
        cur_req = "R2";
        sleep_now(1'b0);
        cyc(4);
        cur_req = "R4";
        wake_sel = 2'b01;
        wake_now();
        cyc(SHORT + 3);

        // R5 every code
        measure(2'b01, SHORT, "R5");
        measure(2'b11, LONG, "R5");
        measure(2'b00, LONG, "R5");
        measure(2'b10, LONG, "R5");

        // R3 regulator kept on; hold_on toggled while asleep
        cur_req = "R3";
        sleep_now(1'b1);
        hold_on = 1'b0;
        cyc(3);
        wake_now();
        // R7 sleep request lands in the release cycle
        cur_req = "R7";
        sleep_req = 1'b1;
        cyc(1);
        sleep_req = 1'b0;
        cyc(3);

        // R6 wakes while running and during settling; R7 sleep during settling
        cur_req = "R6";
        wake_now();
        cyc(1);
        sleep_now(1'b0);
        cyc(2);
        wake_sel = 2'b11;
        wake_now();
        for (int i = 0; i < 5; i++) wake_now();
        cur_req = "R7";
        sleep_now(1'b0);
        cyc(LONG);
        // R10 covered on every compare
        cur_req = "R10";
        cyc(3);

        // R8 under-voltage cuts a settle short
        cur_req = "R8";
        sleep_now(1'b0);
        cyc(1);
        wake_now();
        cyc(4);
        uv_det = 1'b1;
        cyc(1);
        uv_det = 1'b0;
        cyc(3);
        uv_det = 1'b1;
        cyc(2);
        uv_det = 1'b0;
        cyc(2);

        // R9 flag writes
        cur_req = "R9";
        flag_wr_en = 1'b1; flag_wr_val = 1'b1;
        cyc(1);
        flag_wr_val = 1'b0; uv_det = 1'b1;
        cyc(1);
        uv_det = 1'b0;
        cyc(1);
        flag_wr_en = 1'b0;
        cyc(2);
        cmp("bor_flag", bor_flag, 0);
        sleep_now(1'b0);
        cyc(2);
        wake_now();
        cyc(LONG + 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule